// File: doc/BRIEF.md
# Cascadable Shift-and-Hold Open-Drain Driver

This block is a serial-to-parallel driver with two register ranks. Serial bits enter a shift chain on rising edges of a shift clock. A separate storage clock copies the whole chain at once into a holding rank. The holding rank drives a row of open-drain sinks. Each sink either pulls its line low or releases it to high impedance, and an external pull-up sets the idle level.

A serial cascade output carries the last chain stage to the next device. It is re-timed on the falling shift-clock edge, which gives the next stage half a clock period of hold margin when both stages share one shift clock. An active-low asynchronous clear empties every register. An active-low output enable releases every sink without touching the stored data.

Top module: `serial_sink_driver`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 of the chain takes `ser_in` and every stage k (k ≥ 1) takes the old value of stage k-1. Stage WIDTH-1 is the last stage.
- R2: On a rising edge of `store_clk`, all chain stages are copied in parallel into the holding rank. The holding rank keeps its value across any number of `shift_clk` edges.
- R3: While `clr_n` is low, the chain, the holding rank and the cascade flop all read zero at once, with no clock edge needed. Every sink is released and `casc_out` reads 0.
- R4: `casc_out` presents the last chain stage. It changes only on falling `shift_clk` edges, so just after a rising edge it still shows the previous last-stage value.
- R5: With `oe_n` low, line `drv_out[i]` is driven to 0 when holding bit i is 1, and is high impedance ('z') when holding bit i is 0.
- R6: With `oe_n` high, all lines are high impedance. Changing `oe_n` leaves both register ranks unchanged.
- R7: When `shift_clk` and `store_clk` rise together, the holding rank receives the chain contents from before that edge.
- R8: Two devices, with the upstream `casc_out` feeding the downstream `ser_in` and one shared `shift_clk`, load 16 bits in 16 edges with no lost or duplicated bit. The first bit ends in the downstream last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into chain stage 0 |
| shift_clk | input | 1 | Chain clock; the cascade flop uses its falling edge |
| store_clk | input | 1 | Holding-rank transfer clock |
| clr_n | input | 1 | Active-low asynchronous clear of all registers |
| oe_n | input | 1 | Active-low enable of the sink outputs |
| drv_out | output | WIDTH | Open-drain lines: 0 when sinking, 'z' when released |
| casc_out | output | 1 | Re-timed last chain stage, for chaining |

## Verification
The hardest case to reach is the hold race between chained stages. It only shows up when two devices share a shift clock and the downstream device samples at the same edge that moves the upstream last stage. The bench builds exactly this: two instances are chained, and every shift edge is driven on both at once. Each `casc_out` is compared against a 16-bit reference model twice per pulse, once between the rising and falling edges and once after the falling edge. Random shift, store, tied-clock, enable and clear operations from a seeded generator move the pair through many states, and directed runs cover an alternating 16-bit load and a tied-clock transfer.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;
   typedef enum logic {
      CASC_FALL_RETIME  = 1'b0,
      CASC_PASS_THROUGH = 1'b1
   } casc_mode_e;

   localparam int unsigned DEF_WIDTH = 8;
endpackage

// File: rtl/sink_shift_chain.sv
module sink_shift_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             shift_clk,
   input  logic             clr_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q
);
   localparam int unsigned TOP = WIDTH - 1;

   always_ff @(posedge shift_clk or negedge clr_n) begin
      if (!clr_n) stage_q <= '0;
      else        stage_q <= {stage_q[TOP-1:0], ser_in};
   end

   // set after the first edge that follows a clear
   logic armed_q;
   always_ff @(posedge shift_clk or negedge clr_n) begin
      if (!clr_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R1: stages advance by one position per rising edge
   p_shift_move_r1: assert property (@(posedge shift_clk) disable iff (!clr_n)
      armed_q |-> stage_q[TOP:1] == $past(stage_q[TOP-1:0]));
endmodule

// File: rtl/sink_hold_reg.sv
module sink_hold_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             store_clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] load_d,
   output logic [WIDTH-1:0] hold_q
);
   always_ff @(posedge store_clk or negedge clr_n) begin
      if (!clr_n) hold_q <= '0;
      else        hold_q <= load_d;
   end
endmodule

// File: rtl/sink_cascade_tap.sv
module sink_cascade_tap
   import sink_drv_pkg::*;
#(
   parameter casc_mode_e MODE = CASC_FALL_RETIME
) (
   input  logic shift_clk,
   input  logic clr_n,
   input  logic last_stage,
   output logic casc_out
);
   generate
      if (MODE == CASC_FALL_RETIME) begin : g_retime
         logic casc_q;
         logic armed_q;
         always_ff @(negedge shift_clk or negedge clr_n) begin
            if (!clr_n) begin
               casc_q  <= 1'b0;
               armed_q <= 1'b0;
            end else begin
               casc_q  <= last_stage;
               armed_q <= 1'b1;
            end
         end
         assign casc_out = casc_q;

         // R4: at a rising edge the tap still shows the pre-edge last stage
         p_casc_hold_r4: assert property (@(posedge shift_clk) disable iff (!clr_n)
            armed_q |-> casc_out == last_stage);
      end else begin : g_direct
         assign casc_out = last_stage;
      end
   endgenerate
endmodule

// File: rtl/sink_out_stage.sv
module sink_out_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             store_clk,
   input  logic             clr_n,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] hold_q,
   output wire  [WIDTH-1:0] drv_out
);
   logic [WIDTH-1:0] sink_en;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_sink
         assign sink_en[i] = hold_q[i] & ~oe_n;
         assign drv_out[i] = sink_en[i] ? 1'b0 : 1'bz;
      end
   endgenerate

   // R6: a disabled output row sinks nothing
   p_off_release_r6: assert property (@(posedge store_clk) disable iff (!clr_n)
      oe_n |-> sink_en == '0);
   // R5: an enabled row sinks exactly the set holding bits
   p_on_follow_r5: assert property (@(posedge store_clk) disable iff (!clr_n)
      !oe_n |-> sink_en == hold_q);
endmodule

// File: rtl/serial_sink_driver.sv
module serial_sink_driver
   import sink_drv_pkg::*;
#(
   parameter int unsigned WIDTH     = DEF_WIDTH,
   parameter casc_mode_e  CASC_MODE = CASC_FALL_RETIME
) (
   input  logic             ser_in,
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             clr_n,
   input  logic             oe_n,
   output wire  [WIDTH-1:0] drv_out,
   output logic             casc_out
);
   localparam int unsigned LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("serial_sink_driver: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] hold_q;

   sink_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .shift_clk (shift_clk),
      .clr_n     (clr_n),
      .ser_in    (ser_in),
      .stage_q   (stage_q)
   );

   sink_hold_reg #(.WIDTH(WIDTH)) u_hold (
      .store_clk (store_clk),
      .clr_n     (clr_n),
      .load_d    (stage_q),
      .hold_q    (hold_q)
   );

   sink_cascade_tap #(.MODE(CASC_MODE)) u_tap (
      .shift_clk  (shift_clk),
      .clr_n      (clr_n),
      .last_stage (stage_q[LAST]),
      .casc_out   (casc_out)
   );

   sink_out_stage #(.WIDTH(WIDTH)) u_out (
      .store_clk (store_clk),
      .clr_n     (clr_n),
      .oe_n      (oe_n),
      .hold_q    (hold_q),
      .drv_out   (drv_out)
   );
endmodule

// File: tb/test_serial_sink_driver.sv
module test_serial_sink_driver;
   localparam int unsigned W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
   logic clr_n = 1'b0, oe_n = 1'b0;
   wire  [W-1:0] a_drv, b_drv;
   logic a_casc, b_casc;

   for (genvar i = 0; i < W; i++) begin : g_pull
      pullup (a_drv[i]);
      pullup (b_drv[i]);
   end

   serial_sink_driver #(.WIDTH(W)) i_serial_sink_driver (
      .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
      .clr_n(clr_n), .oe_n(oe_n), .drv_out(a_drv), .casc_out(a_casc));

   serial_sink_driver #(.WIDTH(W)) i_serial_sink_driver_dn (
      .ser_in(a_casc), .shift_clk(shift_clk), .store_clk(store_clk),
      .clr_n(clr_n), .oe_n(oe_n), .drv_out(b_drv), .casc_out(b_casc));

   int checks = 0;
   int errors = 0;
   logic [2*W-1:0] chain_m = '0;
   logic [2*W-1:0] hold_m  = '0;

   task automatic check_eq(input string req, input logic [2*W-1:0] act,
                           input logic [2*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] exp_lines(input logic [2*W-1:0] h,
                                                input logic oe);
      logic [2*W-1:0] r;
      for (int i = 0; i < 2*W; i++) r[i] = (!oe && h[i]) ? 1'b0 : 1'b1;
      return r;
   endfunction

   task automatic check_lines(input string req);
      check_eq(req, {b_drv, a_drv}, exp_lines(hold_m, oe_n));
   endtask

   // one shared shift pulse; the tap is checked between and after the edges
   task automatic shift_bit(input logic b, input logic with_store);
      logic [1:0] prev_tap;
      ser_in = b;
      #3;
      prev_tap = {chain_m[2*W-1], chain_m[W-1]};
      if (with_store) hold_m = chain_m;
      chain_m = {chain_m[2*W-2:0], b};
      shift_clk = 1'b1;
      if (with_store) store_clk = 1'b1;
      #1;
      check_eq("R4 tap before falling edge", {14'd0, b_casc, a_casc}, {14'd0, prev_tap});
      #2;
      shift_clk = 1'b0;
      store_clk = 1'b0;
      #1;
      check_eq("R4 tap after falling edge", {14'd0, b_casc, a_casc},
               {14'd0, chain_m[2*W-1], chain_m[W-1]});
   endtask

   task automatic store_pulse();
      #2;
      store_clk = 1'b1;
      hold_m = chain_m;
      #3;
      store_clk = 1'b0;
      #1;
   endtask

   // expose chain contents through the sinks
   task automatic check_chain(input string req);
      store_pulse();
      check_lines(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      #5;
      // R3: reset state
      check_eq("R3 reset lines released", {b_drv, a_drv}, '1);
      check_eq("R3 reset tap zero", {14'd0, b_casc, a_casc}, '0);
      clr_n = 1'b1;
      #5;

      // R1/R8: directed 16-bit alternating-with-marker load through the chain
      for (int n = 0; n < 16; n++) shift_bit((n == 0) | n[0], 1'b0);
      check_chain("R8 16-bit chained load");
      check_eq("R8 first bit in downstream last stage", {15'd0, b_drv[W-1]}, 16'd0);
      check_chain("R1 shift contents");

      // R2: holding rank ignores shift edges
      for (int n = 0; n < 3; n++) shift_bit(n[0], 1'b0);
      check_lines("R2 hold unchanged by shifting");
      check_chain("R2 parallel transfer");

      // R6: enable high releases, toggling keeps state
      oe_n = 1'b1; #2;
      check_lines("R6 disabled lines released");
      check_eq("R6 disabled tap kept", {14'd0, b_casc, a_casc},
               {14'd0, chain_m[2*W-1], chain_m[W-1]});
      oe_n = 1'b0; #2;
      check_lines("R6 hold kept across enable toggle");
      check_lines("R5 enabled lines sink set bits");

      // R7: tied clocks load pre-edge contents
      shift_bit(1'b1, 1'b1);
      #1;
      check_lines("R7 tied clocks one pulse behind");

      // R3: asynchronous clear mid-stream
      clr_n = 1'b0; #1;
      chain_m = '0; hold_m = '0;
      check_eq("R3 clear releases lines", {b_drv, a_drv}, '1);
      check_eq("R3 clear zeroes tap", {14'd0, b_casc, a_casc}, '0);
      #2; clr_n = 1'b1; #2;
      check_chain("R3 chain empty after clear");

      // random mix
      for (int it = 0; it < 300; it++) begin
         int unsigned op;
         op = $urandom % 16;
         if (op < 8)        shift_bit(1'($urandom), 1'b0);
         else if (op < 11)  begin store_pulse(); check_lines("R2 random transfer"); end
         else if (op < 13)  begin shift_bit(1'($urandom), 1'b1); check_lines("R7 random tied pulse"); end
         else if (op < 15)  begin oe_n = ~oe_n; #2; check_lines("R5 R6 random enable"); end
         else begin
            clr_n = 1'b0; #1;
            chain_m = '0; hold_m = '0;
            check_eq("R3 random clear tap", {14'd0, b_casc, a_casc}, '0);
            #1; clr_n = 1'b1; #2;
         end
      end
      oe_n = 1'b0; #2;
      check_chain("R1 R8 final chain contents");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule